// File: doc/BRIEF.md
# Open-Circuit-Voltage Debounce and Restart Sequencer

This block produces the first open-circuit-voltage (OCV) estimate of a battery gauge after power-up, after a battery is swapped, or after a commanded restart. A millisecond strobe paces it. On every tick of a capture window it compares the present 12-bit cell-voltage sample with the largest value seen so far and keeps the larger one. When the window closes, it publishes that peak as the OCV and pulses a ready flag. A fixed delay stands in for the charge model. When that delay runs out, a second pulse reports that the state of charge is available.

A restart can come from four places: a rising edge on an external restart pin (first resynchronised through two flops), a one-clock software write strobe, a swap detector, and the end of reset. The swap detector arms when the cell drops below a programmable threshold and fires once the cell is back above it. It uses a fast comparator when that comparator is available, which gives a short delay. When the comparator is switched off in hibernate, it compares the converter result against the threshold instead, which gives a long delay. Any restart aborts a sequence that is already running and starts a fresh window.

Top module: `ocv_restart_seq`

## Requirements
- R1: Reset release starts a sequence. `ocv_rdy` pulses for one clock after the 17th `ms_tick` of the sequence, and `soc_rdy` pulses for one clock after the 192nd tick (175 ticks after `ocv_rdy`).
- R2: `ocv` is the largest of the `cell_v` values present at ticks 1 to 16 of the sequence. It is updated when `ocv_rdy` pulses and held otherwise. It reads 0 after reset.
- R3: Samples from the 17th tick onward do not change `ocv`. After `soc_rdy`, further ticks produce no ready pulses until the next restart.
- R4: A rising edge on `qs_pin` starts a new sequence after a two-flop synchroniser. Holding the pin high causes only one restart.
- R5: A one-clock `qs_wr` strobe starts a new sequence. The software restart bit clears itself after one clock, and `restart` is high two clocks after the strobe.
- R6: A restart during a running window discards the partial peak. The next `ocv` comes only from the 16 samples of the new window, and only one `ocv_rdy` is produced.
- R7: When the comparator is enabled (not both `cmp_dis` and `hib_mode`), `fast_cmp` low arms swap detection. `fast_cmp` high while armed restarts the sequence on the first following tick.
- R8: When `cmp_dis` and `hib_mode` are both 1, swap detection uses `cell_v` at `cell_upd` strobes. A value below `rst_thr`×32 arms it. A value at or above `rst_thr`×32 while armed restarts the sequence on the 250th following tick.
- R9: Without a preceding drop below the threshold, a cell voltage above the threshold never causes a restart.
- R10: `restart` pulses for one clock for every restart taken, whatever its source. It does not pulse at reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-clock millisecond strobe |
| cell_v | input | 12 | Present cell-voltage sample |
| cell_upd | input | 1 | Strobe: new converter result on `cell_v` |
| fast_cmp | input | 1 | Fast comparator output, 1 = cell above threshold |
| cmp_dis | input | 1 | Turn the fast comparator off while in hibernate |
| hib_mode | input | 1 | Gauge is in hibernate |
| rst_thr | input | 7 | Reset threshold, 40 mV per step (×32 in sample codes) |
| qs_pin | input | 1 | Asynchronous restart pin, rising edge |
| qs_wr | input | 1 | Software restart write strobe |
| ocv | output | 12 | Captured OCV estimate |
| ocv_rdy | output | 1 | OCV ready pulse |
| soc_rdy | output | 1 | SOC ready pulse |
| restart | output | 1 | Restart taken pulse |

## Verification
The hardest case to reach is the slow swap path. It only counts once the detector has been armed by a converter strobe below the threshold and has then seen a later strobe above it, all while both the hibernate and comparator-disable inputs are high. The bench drives that exact order of strobes. It then counts out 249 ticks and checks that no restart has occurred, and checks that the 250th tick produces one. It also checks a strobe above the threshold with no prior drop, which must not restart the sequence. Aborting a half-filled window is reached with a software strobe after eight high samples, followed by sixteen lower ones.

// File: rtl/qsd_pkg.sv
package qsd_pkg;
  typedef enum logic [1:0] {
    PH_ACQ  = 2'd0,
    PH_WAIT = 2'd1,
    PH_IDLE = 2'd2
  } phase_t;
endpackage

// File: rtl/qsd_edge_sync.sv
module qsd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= pin;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];

  assign rise = sync_q[STAGES-1] & ~prev_q;

  a_r4_rise_from_pin: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> $past(pin, STAGES));
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/qsd_swap_det.sv
module qsd_swap_det #(
  parameter int VW       = 12,
  parameter int FAST_DLY = 1,
  parameter int SLOW_DLY = 250
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [VW-1:0] cell_v,
  input  logic          cell_upd,
  input  logic          fast_cmp,
  input  logic          cmp_en,
  input  logic [VW-1:0] thr_v,
  output logic          fire
);
  localparam int CW = $clog2(SLOW_DLY + 1);

  logic          armed_q, armed_n;
  logic          pend_q,  pend_n;
  logic [CW-1:0] cnt_q,   cnt_n;
  logic          fire_q,  fire_n;
  logic          below, above;

  always_comb begin
    below = cmp_en ? ~fast_cmp : (cell_upd && (cell_v <  thr_v));
    above = cmp_en ?  fast_cmp : (cell_upd && (cell_v >= thr_v));
    armed_n = armed_q;
    pend_n  = pend_q;
    cnt_n   = cnt_q;
    fire_n  = 1'b0;
    if (below) begin
      armed_n = 1'b1;
      pend_n  = 1'b0;
    end else if (pend_q) begin
      if (tick) begin
        if (cnt_q == CW'(1)) begin
          fire_n  = 1'b1;
          pend_n  = 1'b0;
          armed_n = 1'b0;
        end else begin
          cnt_n = cnt_q - CW'(1);
        end
      end
    end else if (armed_q && above) begin
      pend_n = 1'b1;
      cnt_n  = cmp_en ? CW'(FAST_DLY) : CW'(SLOW_DLY);
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      cnt_q   <= '0;
      fire_q  <= 1'b0;
    end else begin
      armed_q <= armed_n;
      pend_q  <= pend_n;
      cnt_q   <= cnt_n;
      fire_q  <= fire_n;
    end

  assign fire = fire_q;

  a_r9_fire_after_arm: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(armed_q) && !armed_q);
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (cnt_q >= CW'(1)) && (cnt_q <= CW'(SLOW_DLY)));
endmodule

// File: rtl/qsd_capture.sv
module qsd_capture
  import qsd_pkg::*;
#(
  parameter int VW      = 12,
  parameter int WIN     = 16,
  parameter int OCV_DLY = 17,
  parameter int SOC_DLY = 175
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          tick,
  input  logic [VW-1:0] cell_v,
  output logic [VW-1:0] ocv,
  output logic          ocv_rdy,
  output logic          soc_rdy
);
  localparam int TOTAL = OCV_DLY + SOC_DLY;
  localparam int CW    = $clog2(TOTAL + 1);

  phase_t        ph_q,   ph_n;
  logic [CW-1:0] cnt_q,  cnt_n;
  logic [VW-1:0] peak_q, peak_n;
  logic [VW-1:0] ocv_q,  ocv_n;
  logic          ordy_q, ordy_n;
  logic          srdy_q, srdy_n;

  always_comb begin
    ph_n   = ph_q;
    cnt_n  = cnt_q;
    peak_n = peak_q;
    ocv_n  = ocv_q;
    ordy_n = 1'b0;
    srdy_n = 1'b0;
    if (go) begin
      ph_n   = PH_ACQ;
      cnt_n  = '0;
      peak_n = '0;
    end else if (tick && ph_q != PH_IDLE) begin
      cnt_n = cnt_q + CW'(1);
      if (cnt_q < CW'(WIN) && cell_v > peak_q) peak_n = cell_v;
      if (cnt_n == CW'(OCV_DLY)) begin
        ocv_n  = peak_n;
        ordy_n = 1'b1;
        ph_n   = PH_WAIT;
      end
      if (cnt_n == CW'(TOTAL)) begin
        srdy_n = 1'b1;
        ph_n   = PH_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph_q   <= PH_ACQ;
      cnt_q  <= '0;
      peak_q <= '0;
      ocv_q  <= '0;
      ordy_q <= 1'b0;
      srdy_q <= 1'b0;
    end else begin
      ph_q   <= ph_n;
      cnt_q  <= cnt_n;
      peak_q <= peak_n;
      ocv_q  <= ocv_n;
      ordy_q <= ordy_n;
      srdy_q <= srdy_n;
    end

  assign ocv     = ocv_q;
  assign ocv_rdy = ordy_q;
  assign soc_rdy = srdy_q;

  a_r2_peak_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> peak_q >= $past(peak_q));
  a_r1_ocv_single: assert property (@(posedge clk) disable iff (!rst_n)
    ocv_rdy |=> !ocv_rdy);
  a_r1_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ocv_rdy && soc_rdy));
  a_r3_ocv_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ocv_rdy |-> $stable(ocv));
  a_r3_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && !go) |=> ph_q == PH_IDLE && !ocv_rdy && !soc_rdy);
endmodule

// File: rtl/ocv_restart_seq.sv
module ocv_restart_seq #(
  parameter int VW        = 12,
  parameter int THRW      = 7,
  parameter int THR_SHIFT = 5,
  parameter int WIN       = 16,
  parameter int OCV_DLY   = 17,
  parameter int SOC_DLY   = 175,
  parameter int FAST_DLY  = 1,
  parameter int SLOW_DLY  = 250,
  parameter int SYNC_STG  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ms_tick,
  input  logic [VW-1:0]   cell_v,
  input  logic            cell_upd,
  input  logic            fast_cmp,
  input  logic            cmp_dis,
  input  logic            hib_mode,
  input  logic [THRW-1:0] rst_thr,
  input  logic            qs_pin,
  input  logic            qs_wr,
  output logic [VW-1:0]   ocv,
  output logic            ocv_rdy,
  output logic            soc_rdy,
  output logic            restart
);
  localparam int TW = THRW + THR_SHIFT;

  logic          pin_rise, swap_fire, go, cmp_en;
  logic          sw_q, sw_n;
  logic          rst_q, rst_n_nx;
  logic [TW-1:0] thr_wide;
  logic [VW-1:0] thr_v;

  assign thr_wide = {rst_thr, {THR_SHIFT{1'b0}}};
  assign thr_v    = VW'(thr_wide);
  assign cmp_en   = ~(cmp_dis & hib_mode);
  assign go       = pin_rise | sw_q | swap_fire;

  always_comb begin
    sw_n     = qs_wr;
    rst_n_nx = go;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sw_q  <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      sw_q  <= sw_n;
      rst_q <= rst_n_nx;
    end

  assign restart = rst_q;

  qsd_edge_sync #(.STAGES(SYNC_STG)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin(qs_pin), .rise(pin_rise)
  );

  qsd_swap_det #(.VW(VW), .FAST_DLY(FAST_DLY), .SLOW_DLY(SLOW_DLY)) u_swap (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick), .cell_v(cell_v),
    .cell_upd(cell_upd), .fast_cmp(fast_cmp), .cmp_en(cmp_en),
    .thr_v(thr_v), .fire(swap_fire)
  );

  qsd_capture #(.VW(VW), .WIN(WIN), .OCV_DLY(OCV_DLY), .SOC_DLY(SOC_DLY)) u_cap (
    .clk(clk), .rst_n(rst_n), .go(go), .tick(ms_tick), .cell_v(cell_v),
    .ocv(ocv), .ocv_rdy(ocv_rdy), .soc_rdy(soc_rdy)
  );

  a_r5_sw_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $past(qs_wr, 2) |-> restart);
  a_r10_restart_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> $past(pin_rise) || $past(sw_q) || $past(swap_fire));
endmodule

// File: tb/ocv_restart_seq_bench.sv
module ocv_restart_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ms_tick, cell_upd, fast_cmp, cmp_dis, hib_mode, qs_pin, qs_wr;
  logic [11:0] cell_v;
  logic [6:0]  rst_thr;
  logic [11:0] ocv;
  logic        ocv_rdy, soc_rdy, restart;

  int total = 0;
  int bad   = 0;
  int n_ocv = 0, n_soc = 0, n_rst = 0;
  bit done  = 1'b0;

  // rows: start value, signed step, expected peak over 16 samples
  localparam int NROW = 5;
  localparam int VEC [NROW][3] = '{
    '{100,   10,  250},
    '{3000,  -7,  3000},
    '{4000,   6,  4090},
    '{2048,   0,  2048},
    '{0,      1,  15}
  };

  always #5 clk = ~clk;

  ocv_restart_seq u_ocv_restart_seq (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .cell_v(cell_v),
    .cell_upd(cell_upd), .fast_cmp(fast_cmp), .cmp_dis(cmp_dis),
    .hib_mode(hib_mode), .rst_thr(rst_thr), .qs_pin(qs_pin), .qs_wr(qs_wr),
    .ocv(ocv), .ocv_rdy(ocv_rdy), .soc_rdy(soc_rdy), .restart(restart)
  );

  always @(posedge clk) begin
    if (rst_n && ocv_rdy) n_ocv++;
    if (rst_n && soc_rdy) n_soc++;
    if (rst_n && restart) n_rst++;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick(input int v);
    cell_v  = 12'(v);
    ms_tick = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0;
    idle(3);
  endtask

  task automatic sw_restart();
    qs_wr = 1'b1;
    @(negedge clk);
    qs_wr = 1'b0;
    idle(4);
  endtask

  task automatic upd(input int v);
    cell_v   = 12'(v);
    cell_upd = 1'b1;
    @(negedge clk);
    cell_upd = 1'b0;
    idle(2);
  endtask

  initial begin
    int base, r0, o0;
    rst_n = 1'b0; ms_tick = 1'b0; cell_upd = 1'b0; fast_cmp = 1'b1;
    cmp_dis = 1'b0; hib_mode = 1'b0; qs_pin = 1'b0; qs_wr = 1'b0;
    cell_v = '0; rst_thr = 7'd90;
    idle(3);
    rst_n = 1'b1;
    idle(3);
    chk("R2 reset ocv", ocv, 0);
    chk("R10 no restart at reset", n_rst, 0);

    // R1/R2 power-up sequence, samples 200..1700
    for (int i = 0; i < 16; i++) tick(200 + 100 * i);
    chk("R1 no ocv_rdy after 16 ticks", n_ocv, 0);
    tick(4095);
    chk("R1 ocv_rdy on 17th tick", n_ocv, 1);
    chk("R2 power-up peak", ocv, 1700);
    for (int i = 0; i < 174; i++) tick(4095);
    chk("R1 no soc_rdy before 192nd tick", n_soc, 0);
    chk("R3 later samples ignored", ocv, 1700);
    tick(4095);
    chk("R1 soc_rdy on 192nd tick", n_soc, 1);
    for (int i = 0; i < 20; i++) tick(100);
    chk("R3 quiet after soc_rdy", n_ocv + n_soc, 2);

    // vector table, software restart each row
    for (int r = 0; r < NROW; r++) begin
      r0 = n_rst; o0 = n_ocv;
      sw_restart();
      chk("R5 software restart pulse", n_rst, r0 + 1);
      for (int i = 0; i < 16; i++) tick(VEC[r][0] + VEC[r][1] * i);
      tick(4095);
      chk("R1 table ocv_rdy", n_ocv, o0 + 1);
      chk("R2 table peak", ocv, VEC[r][2]);
    end

    // spike in the middle of the window
    sw_restart();
    for (int i = 0; i < 16; i++) tick(i == 7 ? 4095 : 500);
    tick(0);
    chk("R2 mid-window spike", ocv, 4095);

    // R6 abort a running window
    sw_restart();
    for (int i = 0; i < 8; i++) tick(4000);
    o0 = n_ocv;
    sw_restart();
    for (int i = 0; i < 16; i++) tick(1000);
    chk("R6 no ready before new window ends", n_ocv, o0);
    tick(0);
    chk("R6 single ocv_rdy", n_ocv, o0 + 1);
    chk("R6 peak from new window only", ocv, 1000);

    // R4 pin restart
    r0 = n_rst;
    qs_pin = 1'b1;
    idle(8);
    chk("R4 pin edge restart", n_rst, r0 + 1);
    idle(20);
    chk("R4 held pin no repeat", n_rst, r0 + 1);
    o0 = n_ocv;
    for (int i = 0; i < 16; i++) tick(777);
    tick(0);
    chk("R4 pin starts new sequence", ocv, 777);
    qs_pin = 1'b0;
    idle(6);
    qs_pin = 1'b1;
    idle(8);
    chk("R4 second pin edge", n_rst, r0 + 2);
    qs_pin = 1'b0;

    // R9 and R8 slow path, threshold code 90 -> 2880
    hib_mode = 1'b1; cmp_dis = 1'b1;
    r0 = n_rst;
    upd(3000);
    for (int i = 0; i < 255; i++) tick(3000);
    chk("R9 no restart without drop", n_rst, r0);
    upd(2879);
    upd(2880);
    for (int i = 0; i < 249; i++) tick(2880);
    chk("R8 no restart before 250th tick", n_rst, r0);
    tick(2880);
    chk("R8 restart on 250th tick", n_rst, r0 + 1);

    // R7 fast path
    hib_mode = 1'b0;
    r0 = n_rst;
    fast_cmp = 1'b1;
    idle(4);
    for (int i = 0; i < 3; i++) tick(3000);
    chk("R9 comparator high unarmed", n_rst, r0);
    fast_cmp = 1'b0;
    idle(4);
    fast_cmp = 1'b1;
    idle(6);
    chk("R7 no restart before tick", n_rst, r0);
    tick(3000);
    chk("R7 restart on first tick", n_rst, r0 + 1);
    tick(3000);
    chk("R10 one pulse per restart", n_rst, r0 + 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule